// File: doc/BRIEF.md
# Two-Phase CCD Readout Clock Sequencer

This block produces the digital timing waveforms needed to read a full-frame, two-phase CCD. All timing comes from one system clock. It drives the two vertical phases, the two horizontal phases, the reset-gate pulse, and a sample strobe for an external converter. Five programmable counts set the timing: pixel period, reset pulse width, strobe delay, vertical pulse width and horizontal setup delay. A sixth count sets the integration time.

A frame starts with a start request while the block is idle. The block first integrates with both vertical phases parked low. It then transfers lines one at a time. For each line it runs a three-interval vertical transfer, then a settling gap, and then shifts the horizontal register once per pixel. The reset gate runs at the pixel rate for the whole frame. A one-cycle completion pulse marks the end of the last line. The timing counts are captured when a frame is accepted, so software may rewrite them at any time.

Top module: `ccd_seq`

## Requirements
- R1: Out of reset and while idle, the outputs are as follows: busy low, done low, both vertical phases low, H1 low, H2 high, reset gate low and sample strobe low.
- R2: A start request is taken only while busy is low, and busy rises on the next cycle. The six timing inputs are captured at that moment. A start request or a timing change made during a frame does not alter that frame.
- R3: After busy rises, V1 and V2 both stay low for exactly `integ_i` cycles. V2 then rises.
- R4: Each line transfer holds V2 high for `vpw_i` cycles, then V1 high for `vpw_i` cycles, then both low for `vpw_i` cycles. V1 and V2 are never high together. H2 is high whenever V1 falls.
- R5: From a V1 falling edge to the first H1 rise of that line takes at least `vpw_i + hset_i` cycles. It takes fewer than `vpw_i + hset_i + pix_cnt_i` cycles, because shifting waits for the next pixel boundary.
- R6: Each line shifts PIXELS pixels (default 2267). In each pixel, H1 is high for the first `pix_cnt_i/2` cycles and low for the second half. H2 is always the complement of H1, and H1 falls exactly once per pixel.
- R7: While busy, the reset gate is high for the first `rg_wid_i` cycles of every pixel period. Its rising edges are exactly `pix_cnt_i` cycles apart through integration, transfer and shifting. It is low while idle.
- R8: During shifting only, the sample strobe is high for one cycle per pixel, `adc_dly_i` cycles after the reset gate falls. A delay of 0 means the strobe coincides with the first low cycle.
- R9: A frame contains LINES line transfers (default 1510), counted as V1 falling edges.
- R10: `done_o` is high for one cycle, the first cycle with busy low after the last pixel of the last line. This happens once per frame.

Timing inputs must satisfy: `pix_cnt_i` even and at least 4, `rg_wid_i` at least 1, `rg_wid_i + adc_dly_i < pix_cnt_i`, and `vpw_i`, `hset_i`, `integ_i` at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request |
| pix_cnt_i | input | CW | Pixel period in clocks (even) |
| rg_wid_i | input | CW | Reset-gate high width in clocks |
| adc_dly_i | input | CW | Sample strobe delay after reset-gate fall |
| vpw_i | input | CW | Vertical interval width in clocks |
| hset_i | input | CW | Minimum horizontal setup delay in clocks |
| integ_i | input | CW | Integration length in clocks |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset-gate pulse |
| adc_o | output | 1 | Converter sample strobe |

## Verification
A corrupted pixel-phase counter shows within one pixel period as a reset-gate period or width error. It also shows as an H1 high time other than half the period, or as a strobe delay that drifts. A wrong sequencer state or interval counter shows at the next vertical transfer as a wrong V1/V2 pulse width. It can also show as V1 falling while H2 is low, or as a wrong setup gap. A wrong pixel or line counter shows only when the frame ends, as a wrong count of H1 falls, strobes or V1 falls, or as a misplaced done pulse. Frames are therefore always run to completion and compared as a whole.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INTEG = 3'd1,
    ST_VXFER = 3'd2,
    ST_HSET  = 3'd3,
    ST_SHIFT = 3'd4
  } seq_st_e;
endpackage

// File: rtl/ccd_cfg_hold.sv
// Captures the timing counts when a frame is accepted.
module ccd_cfg_hold #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [CW-1:0] pix_d,
  input  logic [CW-1:0] rgw_d,
  input  logic [CW-1:0] dly_d,
  input  logic [CW-1:0] vpw_d,
  input  logic [CW-1:0] hs_d,
  input  logic [CW-1:0] int_d,
  output logic [CW-1:0] pix_q,
  output logic [CW-1:0] rgw_q,
  output logic [CW-1:0] dly_q,
  output logic [CW-1:0] vpw_q,
  output logic [CW-1:0] hs_q,
  output logic [CW-1:0] int_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      rgw_q <= '0;
      dly_q <= '0;
      vpw_q <= '0;
      hs_q  <= '0;
      int_q <= '0;
    end else if (cap) begin
      pix_q <= pix_d;
      rgw_q <= rgw_d;
      dly_q <= dly_d;
      vpw_q <= vpw_d;
      hs_q  <= hs_d;
      int_q <= int_d;
    end
  end
endmodule

// File: rtl/ccd_pix_timer.sv
// Free-running pixel phase counter: reset gate, horizontal phases, strobe.
module ccd_pix_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          shift,
  input  logic [CW-1:0] pix,
  input  logic [CW-1:0] rgw,
  input  logic [CW-1:0] dly,
  output logic          wrap,
  output logic          rg,
  output logic          adc,
  output logic          h1,
  output logic          h2
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] pc_q, pc_d;
  logic [CW-1:0] half;
  logic [CW:0]   strobe_at;

  assign half      = {1'b0, pix[CW-1:1]};
  assign strobe_at = {1'b0, rgw} + {1'b0, dly};
  assign wrap      = run && (pc_q == pix - ONE);

  always_comb begin
    if (!run)      pc_d = '0;
    else if (wrap) pc_d = '0;
    else           pc_d = pc_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign rg  = run && (pc_q < rgw);
  assign adc = shift && ({1'b0, pc_q} == strobe_at);
  assign h1  = shift && (pc_q < half);
  assign h2  = !h1;
endmodule

// File: rtl/ccd_frame_fsm.sv
// Frame sequencing: integration, vertical transfer, setup, line shift.
module ccd_frame_fsm
  import ccd_seq_pkg::*;
#(
  parameter int CW     = 32,
  parameter int LINES  = 1510,
  parameter int PIXELS = 2267
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wrap,
  input  logic [CW-1:0] integ,
  input  logic [CW-1:0] vpw,
  input  logic [CW-1:0] hs,
  output logic          accept,
  output logic          busy,
  output logic          shift,
  output logic          v1,
  output logic          v2,
  output logic          done
);
  localparam int PXW = (PIXELS > 1) ? $clog2(PIXELS) : 1;
  localparam int LNW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [PXW-1:0] PX_LAST = PXW'(PIXELS - 1);
  localparam logic [LNW-1:0] LN_LAST = LNW'(LINES - 1);
  localparam logic [PXW-1:0] PX_ONE  = PXW'(1);
  localparam logic [LNW-1:0] LN_ONE  = LNW'(1);
  localparam logic [CW-1:0]  ONE     = CW'(1);

  seq_st_e        st_q, st_d;
  logic [CW-1:0]  tc_q, tc_d;
  logic [1:0]     vph_q, vph_d;
  logic [PXW-1:0] px_q, px_d;
  logic [LNW-1:0] ln_q, ln_d;
  logic           done_q, done_d;

  assign accept = start && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    tc_d   = tc_q;
    vph_d  = vph_q;
    px_d   = px_q;
    ln_d   = ln_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_INTEG;
          tc_d = '0;
          ln_d = '0;
        end
      end
      ST_INTEG: begin
        if (tc_q == integ - ONE) begin
          st_d  = ST_VXFER;
          tc_d  = '0;
          vph_d = 2'd0;
        end else begin
          tc_d = tc_q + ONE;
        end
      end
      ST_VXFER: begin
        if (tc_q == vpw - ONE) begin
          tc_d = '0;
          if (vph_q == 2'd2) st_d = ST_HSET;
          else               vph_d = vph_q + 2'd1;
        end else begin
          tc_d = tc_q + ONE;
        end
      end
      ST_HSET: begin
        if (tc_q >= hs - ONE) begin
          if (wrap) begin
            st_d = ST_SHIFT;
            px_d = '0;
          end
        end else begin
          tc_d = tc_q + ONE;
        end
      end
      ST_SHIFT: begin
        if (wrap) begin
          if (px_q == PX_LAST) begin
            if (ln_q == LN_LAST) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              ln_d  = ln_q + LN_ONE;
              st_d  = ST_VXFER;
              tc_d  = '0;
              vph_d = 2'd0;
            end
          end else begin
            px_d = px_q + PX_ONE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tc_q   <= '0;
      vph_q  <= 2'd0;
      px_q   <= '0;
      ln_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tc_q   <= tc_d;
      vph_q  <= vph_d;
      px_q   <= px_d;
      ln_q   <= ln_d;
      done_q <= done_d;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign shift = (st_q == ST_SHIFT);
  assign v2    = (st_q == ST_VXFER) && (vph_q == 2'd0);
  assign v1    = (st_q == ST_VXFER) && (vph_q == 2'd1);
  assign done  = done_q;
endmodule

// File: rtl/ccd_seq.sv
module ccd_seq #(
  parameter int CW     = 32,
  parameter int LINES  = 1510,
  parameter int PIXELS = 2267
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] pix_cnt_i,
  input  logic [CW-1:0] rg_wid_i,
  input  logic [CW-1:0] adc_dly_i,
  input  logic [CW-1:0] vpw_i,
  input  logic [CW-1:0] hset_i,
  input  logic [CW-1:0] integ_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          v1_o,
  output logic          v2_o,
  output logic          h1_o,
  output logic          h2_o,
  output logic          rg_o,
  output logic          adc_o
);
  logic          accept, shift, wrap;
  logic [CW-1:0] pix_q, rgw_q, dly_q, vpw_q, hs_q, int_q;

  ccd_cfg_hold #(.CW(CW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cap(accept),
    .pix_d(pix_cnt_i), .rgw_d(rg_wid_i), .dly_d(adc_dly_i),
    .vpw_d(vpw_i), .hs_d(hset_i), .int_d(integ_i),
    .pix_q(pix_q), .rgw_q(rgw_q), .dly_q(dly_q),
    .vpw_q(vpw_q), .hs_q(hs_q), .int_q(int_q)
  );

  ccd_frame_fsm #(.CW(CW), .LINES(LINES), .PIXELS(PIXELS)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .wrap(wrap),
    .integ(int_q), .vpw(vpw_q), .hs(hs_q),
    .accept(accept), .busy(busy_o), .shift(shift),
    .v1(v1_o), .v2(v2_o), .done(done_o)
  );

  ccd_pix_timer #(.CW(CW)) i_pix (
    .clk(clk), .rst_n(rst_n), .run(busy_o), .shift(shift),
    .pix(pix_q), .rgw(rgw_q), .dly(dly_q),
    .wrap(wrap), .rg(rg_o), .adc(adc_o), .h1(h1_o), .h2(h2_o)
  );
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic v1_o,
  input logic v2_o,
  input logic h1_o,
  input logic h2_o,
  input logic rg_o,
  input logic adc_o
);
  // R1
  idle_rg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rg_o && !v1_o && !v2_o && !adc_o));
  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R4
  v_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1_o && v2_o));
  // R4
  v1_fall_h2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v1_o) |-> h2_o);
  // R6
  h_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h1_o != h2_o);
  // R8
  adc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_o |=> !adc_o);
  // R8
  adc_after_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_o |-> !rg_o);
  // R10
  done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind ccd_seq ccd_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .v1_o(v1_o), .v2_o(v2_o), .h1_o(h1_o), .h2_o(h2_o),
  .rg_o(rg_o), .adc_o(adc_o)
);

// File: tb/test_ccd_seq.sv
module test_ccd_seq;
  localparam int CW = 16;
  localparam int LINES = 3;
  localparam int PIXELS = 5;

  logic clk, rst_n, start_i;
  logic [CW-1:0] pix_cnt_i, rg_wid_i, adc_dly_i, vpw_i, hset_i, integ_i;
  logic busy_o, done_o, v1_o, v2_o, h1_o, h2_o, rg_o, adc_o;

  int n_cmp = 0;
  int n_bad = 0;

  ccd_seq #(.CW(CW), .LINES(LINES), .PIXELS(PIXELS)) i_ccd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pix_cnt_i(pix_cnt_i), .rg_wid_i(rg_wid_i), .adc_dly_i(adc_dly_i),
    .vpw_i(vpw_i), .hset_i(hset_i), .integ_i(integ_i),
    .busy_o(busy_o), .done_o(done_o), .v1_o(v1_o), .v2_o(v2_o),
    .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o), .adc_o(adc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Port monitor (negedge sampled)
  int cyc = 0;
  logic p_busy = 0, p_rg = 0, p_h1 = 0, p_v1 = 0, p_v2 = 0;
  int t_busy, t_rg_r, t_rg_f, t_h1_r, t_v1_r, t_v2_r, t_v1_f;
  bit have_rg, have_rgf, first_v2, await_h1;
  int integ_meas, n_v1f, n_h1f, n_adc, n_done, h2_bad;
  int rp_min, rp_max, rw_min, rw_max, h1_min, h1_max;
  int v1_min, v1_max, v2_min, v2_max, ad_min, ad_max, g_min, g_max;

  function automatic int mn(input int a, input int b); return (a < b) ? a : b; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy_o && !p_busy) begin
        t_busy = cyc; have_rg = 0; have_rgf = 0; first_v2 = 1; await_h1 = 0;
        integ_meas = -1; n_v1f = 0; n_h1f = 0; n_adc = 0; n_done = 0; h2_bad = 0;
        rp_min = 1 << 30; rp_max = -1; rw_min = 1 << 30; rw_max = -1;
        h1_min = 1 << 30; h1_max = -1; v1_min = 1 << 30; v1_max = -1;
        v2_min = 1 << 30; v2_max = -1; ad_min = 1 << 30; ad_max = -1;
        g_min = 1 << 30; g_max = -1;
      end
      if (rg_o && !p_rg) begin
        if (have_rg) begin rp_min = mn(rp_min, cyc - t_rg_r); rp_max = mx(rp_max, cyc - t_rg_r); end
        have_rg = 1; t_rg_r = cyc;
      end
      if (!rg_o && p_rg) begin
        rw_min = mn(rw_min, cyc - t_rg_r); rw_max = mx(rw_max, cyc - t_rg_r);
        have_rgf = 1; t_rg_f = cyc;
      end
      if (adc_o) begin
        n_adc++;
        ad_min = mn(ad_min, cyc - t_rg_f); ad_max = mx(ad_max, cyc - t_rg_f);
      end
      if (h1_o && !p_h1) begin
        t_h1_r = cyc;
        if (await_h1) begin
          g_min = mn(g_min, cyc - t_v1_f); g_max = mx(g_max, cyc - t_v1_f); await_h1 = 0;
        end
      end
      if (!h1_o && p_h1) begin
        n_h1f++; h1_min = mn(h1_min, cyc - t_h1_r); h1_max = mx(h1_max, cyc - t_h1_r);
      end
      if (v2_o && !p_v2) begin
        t_v2_r = cyc;
        if (first_v2) begin integ_meas = cyc - t_busy; first_v2 = 0; end
      end
      if (!v2_o && p_v2) begin v2_min = mn(v2_min, cyc - t_v2_r); v2_max = mx(v2_max, cyc - t_v2_r); end
      if (v1_o && !p_v1) t_v1_r = cyc;
      if (!v1_o && p_v1) begin
        n_v1f++; t_v1_f = cyc; await_h1 = 1;
        if (!h2_o) h2_bad++;
        v1_min = mn(v1_min, cyc - t_v1_r); v1_max = mx(v1_max, cyc - t_v1_r);
      end
      if (done_o) begin
        n_done++;
        if (busy_o) h2_bad = h2_bad + 1000;
      end
    end
    p_busy = busy_o; p_rg = rg_o; p_h1 = h1_o; p_v1 = v1_o; p_v2 = v2_o;
  end

  task automatic run_frame(input int p, input int rw, input int dl, input int vp,
                           input int hs, input int it, input bit poke);
    @(negedge clk);
    pix_cnt_i = CW'(p); rg_wid_i = CW'(rw); adc_dly_i = CW'(dl);
    vpw_i = CW'(vp); hset_i = CW'(hs); integ_i = CW'(it);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      pix_cnt_i = CW'(p + 2); rg_wid_i = CW'(rw + 1); adc_dly_i = '0;
      vpw_i = CW'(vp + 3); hset_i = CW'(hs + 2); integ_i = CW'(it + 5);
      start_i = 1'b1;
      repeat (2) @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_done == 1, "R10 one done per frame", n_done, 1);
    chk(h2_bad == 0, "R4/R10 H2 at V1 fall, done with busy low", h2_bad, 0);
    chk(busy_o == 1'b0, "R2 idle after frame", int'(busy_o), 0);
    chk(integ_meas == it, "R3 integration length", integ_meas, it);
    chk(v2_min == vp && v2_max == vp, "R4 V2 width", v2_max, vp);
    chk(v1_min == vp && v1_max == vp, "R4 V1 width", v1_min, vp);
    chk(n_v1f == LINES, "R9 line count", n_v1f, LINES);
    chk(g_min >= vp + hs, "R5 setup gap min", g_min, vp + hs);
    chk(g_max < vp + hs + p, "R5 setup gap max", g_max, vp + hs + p - 1);
    chk(n_h1f == LINES * PIXELS, "R6 H1 falls", n_h1f, LINES * PIXELS);
    chk(h1_min == p / 2 && h1_max == p / 2, "R6 H1 half period", h1_max, p / 2);
    chk(rp_min == p && rp_max == p, "R7 reset period", rp_max, p);
    chk(rw_min == rw && rw_max == rw, "R7 reset width", rw_max, rw);
    chk(n_adc == LINES * PIXELS, "R8 strobe count", n_adc, LINES * PIXELS);
    chk(ad_min == dl && ad_max == dl, "R8 strobe delay", ad_max, dl);
    chk(rg_o == 1'b0, "R7 reset gate low idle", int'(rg_o), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b0;
    pix_cnt_i = '0; rg_wid_i = '0; adc_dly_i = '0; vpw_i = '0; hset_i = '0; integ_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 reset busy/done", int'(busy_o) + int'(done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(v1_o == 0 && v2_o == 0, "R1 idle vertical", int'(v1_o) + int'(v2_o), 0);
    chk(h1_o == 0 && h2_o == 1, "R1 idle horizontal", int'(h1_o), 0);
    chk(rg_o == 0 && adc_o == 0, "R1 idle reset/strobe", int'(rg_o) + int'(adc_o), 0);
    // directed corners: minimal counts, then strobe at last phase with poke
    run_frame(4, 1, 0, 1, 1, 1, 1'b0);
    run_frame(16, 3, 12, 12, 10, 40, 1'b1);
    run_frame(6, 5, 0, 2, 3, 9, 1'b1);
    for (int k = 0; k < 6; k++) begin
      int p, rw, dl;
      p  = 2 * int'($urandom_range(8, 2));
      rw = int'($urandom_range(p - 2, 1));
      dl = int'($urandom_range(p - 1 - rw, 0));
      run_frame(p, rw, dl, int'($urandom_range(12, 1)), int'($urandom_range(10, 1)),
                int'($urandom_range(40, 1)), k[0]);
    end
    finish_run();
  end
endmodule